// File: doc/BRIEF.md
# Host Register and Palette Access Port

This block sits behind an 8-bit host port with an active-low chip select, a read/write line and two address lines. Through it a host processor reaches two things: a bank of 8-bit control registers, addressed by a control pointer, and a 256-entry palette whose entries hold three 8-bit colour components, addressed by a palette pointer. The host first loads a pointer and then streams data. Each data access advances the pointer, so long runs of registers or palette entries can be read or written without reloading an address.

The control pointer has three exception addresses. At 0x40 it stops advancing, which lets the host repeat accesses to one test-data location. At 0x50 it does not advance either, which lets the host make several writes to one mask location. Address 0x1F is a status location: a read returns the live `status_in` value, and a write stores nothing but still advances the pointer. The palette pointer carries a two-bit component index that counts red, green, blue and then moves to the next entry. Palette writes are staged and reach the array only when the blue component arrives, so an entry is always replaced as a whole.

The port is synchronous. Every clock edge with `cs_n` low is one access. Read data is presented combinationally in the same cycle as the access. Pointer movement takes effect at the clock edge that closes the access.

Top module: `hostport_regpal`

## Requirements
- R1: `addr` selects the target: 2'b00 is the control pointer, 2'b01 the palette pointer, 2'b10 the control register at the control pointer, and 2'b11 the palette component at the palette pointer. `rw`=1 reads and `rw`=0 writes. A read drives the target onto `dout` in the same cycle with `dout_oe`=1.
- R2: While `cs_n` is high, `dout_oe` is 0, and no pointer, register or palette state changes whatever the other inputs are.
- R3: A write with `addr`=2'b00 loads the control pointer. A read with `addr`=2'b00 returns it and does not move it.
- R4: Each control data access (`addr`=2'b10, read or write) advances the control pointer by one, wrapping from 0xFF to 0x00. Locations 0x00 to 0x5F other than 0x1F store written data. Reads from 0x60 and above return 0.
- R5: A control data access at pointer 0x40 leaves the pointer at 0x40, so repeated accesses hit the same location.
- R6: A control data access at pointer 0x50 leaves the pointer at 0x50, so repeated writes go to the same location.
- R7: A read at control pointer 0x1F returns `status_in`. A write there stores nothing but advances the pointer to 0x20.
- R8: A write with `addr`=2'b01 loads the palette entry pointer and clears the component index to red (0). A read with `addr`=2'b01 returns the entry pointer and does not move it.
- R9: Each palette data access steps the component index red(0), green(1), blue(2). After blue, the index returns to red and the entry pointer advances by one, wrapping from 0xFF to 0x00.
- R10: A palette entry changes only when its blue component is written. That write stores the staged red and green together with the blue. An incomplete red/green sequence leaves the stored entry unchanged.
- R11: After reset both pointers are 0, the component index is red, and all control registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; low for one cycle makes one access |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Target select (see R1) |
| din | input | 8 | Write data |
| status_in | input | 8 | Live status value returned at control location 0x1F |
| dout | output | 8 | Read data, valid while dout_oe is 1 |
| dout_oe | output | 1 | Read data drive enable (low means the bus is released) |

## Verification
Read data depends only on the state held before the access edge, so the bench drives each access on the falling clock edge and compares `dout` and `dout_oe` one nanosecond later, in the same cycle. Every pointer move, register store and palette commit lands on the next rising edge, where the behavioural model updates its own state. The effect of each access is therefore checked by the first access that follows it. Partial palette writes, the exception addresses and the wrap points are each followed at once by read-backs through the port that would expose a wrong pointer or a wrong stored value.

// File: rtl/hp_pkg.sv
// Package: shared types for the host register/palette port.
// Assumes an 8-bit data path; the select encoding matches the addr pins.
package hp_pkg;
    typedef enum logic [1:0] {
        SEL_CPTR = 2'b00,
        SEL_PPTR = 2'b01,
        SEL_CREG = 2'b10,
        SEL_PAL  = 2'b11
    } hp_sel_e;

    localparam logic [1:0] COMP_RED   = 2'd0;
    localparam logic [1:0] COMP_GREEN = 2'd1;
    localparam logic [1:0] COMP_BLUE  = 2'd2;
endpackage

// File: rtl/hp_ctrl_bank.sv
// Control register bank with its self-advancing pointer.
// Holds DEPTH byte registers in a 2**AW address space. Addresses at or above
// DEPTH read as zero and ignore writes. STAT_ADDR is a read-only window onto
// status_in. The pointer stops at STOP_ADDR and HOLD_ADDR and otherwise
// advances by one per data access. Assumes one access per enabled cycle.
module hp_ctrl_bank #(
    parameter int DW        = 8,
    parameter int AW        = 8,
    parameter int DEPTH     = 96,
    parameter int STAT_ADDR = 8'h1F,
    parameter int STOP_ADDR = 8'h40,
    parameter int HOLD_ADDR = 8'h50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_wr,
    input  logic          data_acc,
    input  logic          data_wr,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] status_in,
    output logic [AW-1:0] ptr_q,
    output logic [DW-1:0] rdata
);
    localparam int             SPACE = 2 ** AW;
    localparam logic [AW-1:0]  STAT  = AW'(STAT_ADDR);
    localparam logic [AW-1:0]  STOP  = AW'(STOP_ADDR);
    localparam logic [AW-1:0]  HOLD  = AW'(HOLD_ADDR);

    logic [DW-1:0] regs [SPACE];
    logic [AW-1:0] ptr_next;

    // Pointer step rule: freeze at the stop and hold addresses.
    always_comb begin
        if (ptr_q == STOP || ptr_q == HOLD) ptr_next = ptr_q;
        else                                ptr_next = ptr_q + 1'b1;
    end

    // Pointer register: loaded by the host or stepped by data accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (ptr_wr)   ptr_q <= din[AW-1:0];
        else if (data_acc) ptr_q <= ptr_next;
    end

    // One storage byte per implemented address; the rest read as zero.
    for (genvar i = 0; i < SPACE; i++) begin : g_reg
        if (i < DEPTH && i != STAT_ADDR) begin : g_store
            // Byte store written when the pointer selects it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (data_wr && ptr_q == AW'(i))
                    regs[i] <= din;
            end
        end else begin : g_tie
            assign regs[i] = '0;
        end
    end

    // Read mux: the status window overrides the (empty) storage slot.
    always_comb begin
        if (ptr_q == STAT) rdata = status_in;
        else               rdata = regs[ptr_q];
    end
endmodule

// File: rtl/hp_palette.sv
// Palette array with its entry pointer and red/green/blue component index.
// Red and green writes are staged in holding bytes; the blue write commits
// all three components to the entry in one step and advances the entry.
// The array has no reset; the host is expected to load entries before use.
module hp_palette #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_wr,
    input  logic          data_acc,
    input  logic          data_wr,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] ptr_q,
    output logic [1:0]    sub_q,
    output logic [DW-1:0] rdata
);
    import hp_pkg::*;

    localparam int ENTRIES = 2 ** AW;
    localparam int EW      = 3 * DW;

    logic [EW-1:0] mem [ENTRIES];
    logic [DW-1:0] hold_r, hold_g;
    logic [EW-1:0] cur;
    logic          last_comp;

    assign last_comp = (sub_q == COMP_BLUE);
    assign cur       = mem[ptr_q];

    // Entry pointer and component index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            sub_q <= COMP_RED;
        end else if (ptr_wr) begin
            ptr_q <= din[AW-1:0];
            sub_q <= COMP_RED;
        end else if (data_acc) begin
            if (last_comp) begin
                sub_q <= COMP_RED;
                ptr_q <= ptr_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    // Staging bytes for the first two components of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_r <= '0;
            hold_g <= '0;
        end else if (data_wr) begin
            if (sub_q == COMP_RED)   hold_r <= din;
            if (sub_q == COMP_GREEN) hold_g <= din;
        end
    end

    // Whole-entry commit on the blue write.
    always_ff @(posedge clk) begin
        if (data_wr && last_comp)
            mem[ptr_q] <= {hold_r, hold_g, din};
    end

    // Component select for reads.
    always_comb begin
        unique case (sub_q)
            COMP_RED:   rdata = cur[EW-1 -: DW];
            COMP_GREEN: rdata = cur[2*DW-1 -: DW];
            default:    rdata = cur[DW-1:0];
        endcase
    end
endmodule

// File: rtl/hostport_regpal.sv
// Top level of the host register/palette port.
// Decodes chip select, read/write and the two address lines into pointer
// loads and data accesses for the control bank and the palette, and muxes
// read data. Every clock with cs_n low is one access; read data is
// combinational from state held before the closing edge.
module hostport_regpal #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rw,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] status_in,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    import hp_pkg::*;

    hp_sel_e       sel;
    logic          acc, wr;
    logic [AW-1:0] cptr_q, pptr_q;
    logic [1:0]    psub_q;
    logic [DW-1:0] creg_rd, pal_rd;

    assign sel = hp_sel_e'(addr);
    assign acc = ~cs_n;
    assign wr  = acc & ~rw;

    hp_ctrl_bank #(.DW(DW), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr    (wr && sel == SEL_CPTR),
        .data_acc  (acc && sel == SEL_CREG),
        .data_wr   (wr && sel == SEL_CREG),
        .din       (din),
        .status_in (status_in),
        .ptr_q     (cptr_q),
        .rdata     (creg_rd)
    );

    hp_palette #(.DW(DW), .AW(AW)) u_pal (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_wr   (wr && sel == SEL_PPTR),
        .data_acc (acc && sel == SEL_PAL),
        .data_wr  (wr && sel == SEL_PAL),
        .din      (din),
        .ptr_q    (pptr_q),
        .sub_q    (psub_q),
        .rdata    (pal_rd)
    );

    // Read data select and bus drive enable.
    always_comb begin
        dout_oe = acc & rw;
        unique case (sel)
            SEL_CPTR: dout = DW'(cptr_q);
            SEL_PPTR: dout = DW'(pptr_q);
            SEL_CREG: dout = creg_rd;
            default:  dout = pal_rd;
        endcase
    end
endmodule

// File: rtl/hp_port_checker.sv
// Checker for hostport_regpal: pointer sequencing rules over time.
// Bound to every instance of the top module below.
module hp_port_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rw,
    input logic [1:0]    addr,
    input logic          dout_oe,
    input logic [AW-1:0] cptr,
    input logic [AW-1:0] pptr,
    input logic [1:0]    psub
);
    localparam logic [AW-1:0] STOP = AW'(8'h40);
    localparam logic [AW-1:0] HOLD = AW'(8'h50);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(cptr) && $stable(pptr) && $stable(psub)));

    assert_no_drive_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dout_oe);

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && addr == 2'b10 && cptr != STOP && cptr != HOLD)
        |=> cptr == AW'($past(cptr) + 1'b1));

    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && addr == 2'b10 && cptr == STOP) |=> cptr == STOP);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && addr == 2'b10 && cptr == HOLD) |=> cptr == HOLD);

    assert_ppload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rw && addr == 2'b01) |=> psub == 2'd0);

    assert_sub_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        psub != 2'd3);

    assert_entry_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && addr == 2'b11 && psub == 2'd2)
        |=> (psub == 2'd0 && pptr == AW'($past(pptr) + 1'b1)));
endmodule

bind hostport_regpal hp_port_checker #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rw      (rw),
    .addr    (addr),
    .dout_oe (dout_oe),
    .cptr    (cptr_q),
    .pptr    (pptr_q),
    .psub    (psub_q)
);

// File: tb/sim_hostport_regpal.sv
// Bench: behavioural reference model of the host port, compared every access.
module sim_hostport_regpal;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rw = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] status_in = 8'h3C;
    logic [7:0] dout;
    logic       dout_oe;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference model state
    int m_creg [256];
    int m_pal  [256][3];
    int m_cptr = 0, m_pptr = 0, m_sub = 0, m_hr = 0, m_hg = 0;

    always #5 clk = ~clk;

    hostport_regpal u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
        .din(din), .status_in(status_in), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_cptr;
            1: return m_pptr;
            2: return (m_cptr == 'h1F) ? int'(status_in) : m_creg[m_cptr];
            default: return m_pal[m_pptr][m_sub];
        endcase
    endfunction

    task automatic model_update(input bit cs, input bit r, input int a, input int d);
        if (cs) return;
        case (a)
            0: if (!r) m_cptr = d;
            1: if (!r) begin m_pptr = d; m_sub = 0; end
            2: begin
                if (!r && m_cptr < 'h60 && m_cptr != 'h1F) m_creg[m_cptr] = d;
                if (m_cptr != 'h40 && m_cptr != 'h50) m_cptr = (m_cptr + 1) % 256;
            end
            default: begin
                if (!r) begin
                    if (m_sub == 0) m_hr = d;
                    else if (m_sub == 1) m_hg = d;
                    else begin
                        m_pal[m_pptr][0] = m_hr;
                        m_pal[m_pptr][1] = m_hg;
                        m_pal[m_pptr][2] = d;
                    end
                end
                if (m_sub == 2) begin m_sub = 0; m_pptr = (m_pptr + 1) % 256; end
                else m_sub++;
            end
        endcase
    endtask

    // One access: drive at falling edge, compare 1 ns later, model at rising edge.
    task automatic acc(input string req, input bit cs, input bit r,
                       input int a, input int d);
        @(negedge clk);
        cs_n = cs; rw = r; addr = 2'(a); din = 8'(d);
        #1;
        check({req, " oe"}, int'(dout_oe), int'(!cs && r));
        if (!cs && r) check(req, int'(dout), model_read(a));
        @(posedge clk);
        model_update(cs, r, a, d);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_creg[i] = 0;
            for (int c = 0; c < 3; c++) m_pal[i][c] = 0;
        end
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R11 oe in reset", int'(dout_oe), 0);
        @(negedge clk); rst_n = 1'b1;
        acc("R11 cptr", 0, 1, 0, 0);
        acc("R11 pptr", 0, 1, 1, 0);
        acc("R11 creg0", 0, 1, 2, 0);
        acc("R3 cptr load", 0, 0, 0, 'h10);
        acc("R3 cptr readback", 0, 1, 0, 0);
        acc("R3 cptr stable", 0, 1, 0, 0);

        // Fill the palette so every read has a known value (R10, R9)
        acc("R8 pptr load", 0, 0, 1, 0);
        for (int i = 0; i < 768; i++) acc("R10 fill", 0, 0, 3, (i * 7 + 3) % 256);
        acc("R9 pptr wrap after fill", 0, 1, 1, 0);

        // R4: sequential control writes and read-back
        acc("R3 load", 0, 0, 0, 'h10);
        for (int i = 0; i < 4; i++) acc("R4 write", 0, 0, 2, 'hA1 + i);
        acc("R4 ptr after writes", 0, 1, 0, 0);
        acc("R3 load", 0, 0, 0, 'h10);
        for (int i = 0; i < 4; i++) acc("R4 readback", 0, 1, 2, 0);
        acc("R1 creg select", 0, 1, 0, 0);

        // R2: deselected cycles change nothing and release the bus
        acc("R2 idle read", 1, 1, 2, 0);
        acc("R2 idle write", 1, 0, 2, 'hEE);
        acc("R2 idle ptr write", 1, 0, 0, 'h77);
        acc("R2 idle pal write", 1, 0, 3, 'h99);
        acc("R2 cptr unchanged", 0, 1, 0, 0);
        acc("R2 pptr unchanged", 0, 1, 1, 0);
        acc("R3 load", 0, 0, 0, 'h14);
        acc("R2 reg unchanged", 0, 1, 2, 0);

        // R7: status address
        acc("R3 load", 0, 0, 0, 'h1E);
        acc("R7 write 1E", 0, 0, 2, 'h55);
        acc("R7 write 1F", 0, 0, 2, 'h66);
        acc("R7 ptr past status", 0, 1, 0, 0);
        acc("R3 load", 0, 0, 0, 'h1F);
        acc("R7 status read", 0, 1, 2, 0);
        status_in = 8'hC5;
        acc("R3 load", 0, 0, 0, 'h1F);
        acc("R7 status live", 0, 1, 2, 0);

        // R5: stop address
        acc("R3 load", 0, 0, 0, 'h3F);
        acc("R5 write 3F", 0, 0, 2, 'h11);
        acc("R5 write 40", 0, 0, 2, 'h22);
        acc("R5 write 40 again", 0, 0, 2, 'h33);
        acc("R5 ptr stuck", 0, 1, 0, 0);
        acc("R5 read last", 0, 1, 2, 0);
        acc("R5 ptr after read", 0, 1, 0, 0);

        // R6: hold address
        acc("R3 load", 0, 0, 0, 'h50);
        acc("R6 write a", 0, 0, 2, 'h0F);
        acc("R6 write b", 0, 0, 2, 'hF0);
        acc("R6 ptr held", 0, 1, 0, 0);
        acc("R6 read", 0, 1, 2, 0);

        // R4: wrap and unimplemented space
        acc("R3 load", 0, 0, 0, 'hFF);
        acc("R4 write unimpl", 0, 0, 2, 'hAB);
        acc("R4 ptr wrap", 0, 1, 0, 0);
        acc("R3 load", 0, 0, 0, 'h5F);
        acc("R4 write 5F", 0, 0, 2, 'h5A);
        acc("R4 read unimpl 60", 0, 1, 2, 0);
        acc("R3 load", 0, 0, 0, 'h5F);
        acc("R4 read 5F", 0, 1, 2, 0);

        // R9 / R1: palette sequence across two entries
        acc("R8 pptr load", 0, 0, 1, 5);
        for (int i = 0; i < 6; i++) acc("R9 pal write", 0, 0, 3, 'h40 + i);
        acc("R9 entry advanced", 0, 1, 1, 0);
        acc("R8 pptr load", 0, 0, 1, 5);
        for (int i = 0; i < 6; i++) acc("R9 pal read", 0, 1, 3, 0);
        acc("R9 entry after reads", 0, 1, 1, 0);

        // R10 / R8: partial write then pointer reload
        acc("R8 pptr load", 0, 0, 1, 5);
        acc("R10 partial red", 0, 0, 3, 'hDE);
        acc("R10 partial green", 0, 0, 3, 'hAD);
        acc("R8 pptr reload", 0, 0, 1, 5);
        acc("R8 pptr read", 0, 1, 1, 0);
        for (int i = 0; i < 3; i++) acc("R10 entry unchanged", 0, 1, 3, 0);
        acc("R8 pptr load", 0, 0, 1, 9);
        acc("R10 red", 0, 0, 3, 'h01);
        acc("R10 green", 0, 0, 3, 'h02);
        acc("R8 pptr load", 0, 0, 1, 9);
        acc("R10 red only staged", 0, 1, 3, 0);

        // R9: entry pointer wrap
        acc("R8 pptr load", 0, 0, 1, 'hFF);
        for (int i = 0; i < 3; i++) acc("R9 last entry", 0, 0, 3, 'hC0 + i);
        acc("R9 pptr wrap", 0, 1, 1, 0);
        acc("R8 pptr load", 0, 0, 1, 'hFF);
        for (int i = 0; i < 3; i++) acc("R9 last entry read", 0, 1, 3, 0);

        // Mixed traffic against the model (R1)
        for (int i = 0; i < 600; i++) begin
            automatic int a = int'($urandom_range(0, 3));
            automatic int d = int'($urandom_range(0, 255));
            automatic bit r = 1'($urandom_range(0, 1));
            automatic bit c = ($urandom_range(0, 7) == 0);
            if (a < 2 && !r && $urandom_range(0, 3) != 0) r = 1'b1;
            acc("R1 mixed", c, r, a, d);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule